// File: doc/BRIEF.md
# Predecode-Tagged Instruction Steering Unit

This block sits between a byte queue and the decoders. Each cycle the byte queue offers a window of instruction bytes. Every byte carries a tag: one bit marks the first byte of an instruction, one bit marks its last byte, and on the first byte a small field gives how many internal operations the instruction expands into. The block never works out instruction length by itself. It walks the tags from the start of the window, splits the window into instructions, and places them in program order into up to four decode positions. An instruction that expands into fewer than four operations goes down the fast path. An instruction that expands into four or more is handed to a microcode sequencer port.

The block registers each group it accepts. Each decode position carries the instruction's length, its operation count and its bytes left-aligned. In the same cycle it tells the byte queue how many bytes it took, so the queue can shift the next instruction to offset zero. A flush drops any registered group and any pending microcode hand-off.

Top module: `steer_unit`

## Requirements
- R1: After reset or a flush, `pos_valid` is 0 and `mc_valid` is 0. `win_take` is 0 in any cycle in which `flush` is high.
- R2: Instruction k starts at the byte that follows instruction k-1, and instruction 0 starts at offset 0. Its length is the distance from its start to the next byte whose last-bit (tag bit 1) is set, plus one. It counts only if its first byte has the first-bit (tag bit 0) set. Lengths range from 1 to 15.
- R3: An instruction whose operation count (tag bits 4:2) is 3 or less is fast-path. Fast-path instructions fill decode positions 0 upward in program order, at most 4 per group. `pos_valid` is always a contiguous run starting at bit 0.
- R4: The operation counts of one group add up to at most 4. Filling stops at the first instruction that would push the total past 4.
- R5: When the instruction at offset 0 has an operation count of 4 or more, it is loaded into the microcode port (`mc_valid`, `mc_len`, `mc_uops`, `mc_bytes`) and no fast-path group is formed. When such an instruction follows fast-path instructions, the group stops just before it.
- R6: While `mc_valid` is high, `win_take` stays 0. If `mc_ready` is low, the microcode outputs stay unchanged. In the cycle after `mc_ready` is seen high, `mc_valid` falls and steering resumes.
- R7: An instruction whose last byte is not below `win_count` is not issued, nor is anything after it. If it is instruction 0, `win_take` stays 0.
- R8: `win_take` is high in the cycle a group or a microcode instruction is accepted. `take_len` then equals the summed length of the instructions accepted.
- R9: While `pos_valid` is non-zero and `dec_ready` is low, the group outputs hold and no fast-path group is accepted.
- R10: Each position's byte field holds the instruction's bytes from the window, byte k at bits 8k+7:8k, and zero above its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all registered and pending state |
| win_valid | input | 1 | Window present |
| win_bytes | input | 256 | Window bytes, byte j at bits 8j+7:8j |
| win_tags | input | 160 | Per-byte tag, byte j at bits 5j+4:5j: bit0 first, bit1 last, bits4:2 operation count |
| win_count | input | 6 | Number of valid window bytes (0..32) |
| win_take | output | 1 | Bytes consumed this cycle |
| take_len | output | 6 | Number of bytes consumed |
| dec_ready | input | 1 | Decoders accept the registered group |
| pos_valid | output | 4 | Occupied decode positions |
| pos_len | output | 16 | Length per position, 4 bits each |
| pos_uops | output | 12 | Operation count per position, 3 bits each |
| pos_bytes | output | 480 | Instruction bytes per position, 120 bits each |
| mc_valid | output | 1 | Microcode instruction pending |
| mc_ready | input | 1 | Sequencer accepts the microcode instruction |
| mc_len | output | 4 | Length of microcode instruction |
| mc_uops | output | 3 | Operation count of microcode instruction |
| mc_bytes | output | 120 | Bytes of microcode instruction |

## Verification
The checks assume that the window always begins on an instruction boundary, that every instruction's operation count is at least one, and that the window is held steady by its source until it is taken. The bench builds each window from a list of instruction lengths and counts, placing first-bits and last-bits only where its own list puts instruction edges. Every window starts at offset zero. Incomplete instructions are produced only by shrinking `win_count`, never by malformed tags.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int UOP_W = 3;

    typedef struct packed {
        logic [UOP_W-1:0] uops;
        logic             last;
        logic             first;
    } tag_t;

    localparam int TAG_W = $bits(tag_t);

endpackage

// File: rtl/steer_boundary.sv
module steer_boundary
    import steer_pkg::*;
#(
    parameter int WIN  = 32,
    parameter int MAXL = 15,
    parameter int IW   = 6,
    parameter int LW   = 4
) (
    input  tag_t [WIN-1:0]   tags,
    input  logic [IW-1:0]    start,
    input  logic [IW-1:0]    count,
    output logic             found,
    output logic [LW-1:0]    len,
    output logic [UOP_W-1:0] uops
);
    localparam int OW = $clog2(WIN);

    logic head_ok;

    always_comb begin
        head_ok = 1'b0;
        uops    = '0;
        if (start < count) begin
            head_ok = tags[start[OW-1:0]].first;
            uops    = tags[start[OW-1:0]].uops;
        end
    end

    always_comb begin
        found = 1'b0;
        len   = '0;
        for (int j = 0; j < MAXL; j++) begin
            logic [IW-1:0] idx;
            idx = start + IW'(j);
            if (!found && head_ok && idx < count) begin
                if (tags[idx[OW-1:0]].last) begin
                    found = 1'b1;
                    len   = LW'(j + 1);
                end
            end
        end
    end

endmodule

// File: rtl/steer_extract.sv
module steer_extract #(
    parameter int WIN  = 32,
    parameter int MAXL = 15,
    parameter int IW   = 6,
    parameter int LW   = 4
) (
    input  logic [WIN-1:0][7:0]  bytes,
    input  logic [IW-1:0]        start,
    input  logic [LW-1:0]        len,
    output logic [MAXL-1:0][7:0] out
);
    localparam int OW = $clog2(WIN);

    always_comb begin
        for (int k = 0; k < MAXL; k++) begin
            logic [IW-1:0] idx;
            idx    = start + IW'(k);
            out[k] = 8'h00;
            if (LW'(k) < len && idx < IW'(WIN))
                out[k] = bytes[idx[OW-1:0]];
        end
    end

endmodule

// File: rtl/steer_unit.sv
module steer_unit
    import steer_pkg::*;
#(
    parameter int WIN       = 32,
    parameter int POS       = 4,
    parameter int MAXL      = 15,
    parameter int OP_BUDGET = 4,
    parameter int FAST_MAX  = 3,
    localparam int LW = $clog2(MAXL + 1),
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     win_valid,
    input  logic [WIN*8-1:0]         win_bytes,
    input  logic [WIN*TAG_W-1:0]     win_tags,
    input  logic [CW-1:0]            win_count,
    output logic                     win_take,
    output logic [CW-1:0]            take_len,
    input  logic                     dec_ready,
    output logic [POS-1:0]           pos_valid,
    output logic [POS*LW-1:0]        pos_len,
    output logic [POS*UOP_W-1:0]     pos_uops,
    output logic [POS*MAXL*8-1:0]    pos_bytes,
    output logic                     mc_valid,
    input  logic                     mc_ready,
    output logic [LW-1:0]            mc_len,
    output logic [UOP_W-1:0]         mc_uops,
    output logic [MAXL*8-1:0]        mc_bytes
);
    localparam int IW = $clog2(WIN + MAXL + 1);
    localparam int BW = $clog2(OP_BUDGET + (1 << UOP_W) + 1);
    localparam int SW = $clog2(POS * (1 << UOP_W) + 1);

    logic [WIN-1:0][7:0] wb;
    tag_t [WIN-1:0]      wt;
    logic [IW-1:0]       cnt;

    assign wb  = win_bytes;
    assign wt  = win_tags;
    assign cnt = IW'(win_count);

    // scan chain, one stage per decode position
    logic [POS:0][IW-1:0]          st;
    logic [POS:0]                  ok;
    logic [POS:0][BW-1:0]          used;
    logic [POS-1:0]                fnd;
    logic [POS-1:0]                fast;
    logic [POS-1:0][LW-1:0]        ln;
    logic [POS-1:0][UOP_W-1:0]     up;
    logic [POS-1:0][MAXL-1:0][7:0] ext;

    assign st[0]   = '0;
    assign ok[0]   = win_valid;
    assign used[0] = '0;

    for (genvar g = 0; g < POS; g++) begin : g_stage
        steer_boundary #(.WIN(WIN), .MAXL(MAXL), .IW(IW), .LW(LW)) u_bnd (
            .tags(wt), .start(st[g]), .count(cnt),
            .found(fnd[g]), .len(ln[g]), .uops(up[g])
        );
        steer_extract #(.WIN(WIN), .MAXL(MAXL), .IW(IW), .LW(LW)) u_ext (
            .bytes(wb), .start(st[g]), .len(ln[g]), .out(ext[g])
        );
        assign fast[g] = ok[g] && fnd[g] && (up[g] <= UOP_W'(FAST_MAX))
                         && (used[g] + BW'(up[g]) <= BW'(OP_BUDGET));
        assign ok[g+1]   = fast[g];
        assign st[g+1]   = st[g] + IW'(ln[g]);
        assign used[g+1] = used[g] + BW'(up[g]);
    end

    logic [IW-1:0] fast_tot;
    always_comb begin
        fast_tot = '0;
        for (int g = 0; g < POS; g++)
            if (fast[g]) fast_tot = st[g+1];
    end

    // steering decisions
    logic mc_q, out_free, mc_sel, fire_fast, fire_mc;

    assign out_free  = !(|pos_valid) || dec_ready;
    assign mc_sel    = win_valid && fnd[0] && (up[0] > UOP_W'(FAST_MAX));
    assign fire_mc   = !flush && !mc_q && mc_sel;
    assign fire_fast = !flush && !mc_q && out_free && fast[0];
    assign win_take  = fire_fast || fire_mc;
    assign take_len  = fire_mc ? CW'(ln[0]) : (fire_fast ? CW'(fast_tot) : '0);

    // decode position registers
    logic [POS-1:0]                grp_v;
    logic [POS-1:0][LW-1:0]        r_len;
    logic [POS-1:0][UOP_W-1:0]     r_up;
    logic [POS-1:0][MAXL-1:0][7:0] r_by;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            grp_v <= '0;
        end else if (out_free) begin
            grp_v <= fire_fast ? fast : '0;
            r_len <= ln;
            r_up  <= up;
            r_by  <= ext;
        end
    end

    assign pos_valid = grp_v;
    assign pos_len   = r_len;
    assign pos_uops  = r_up;
    assign pos_bytes = r_by;

    // microcode hand-off register
    logic [LW-1:0]         m_len;
    logic [UOP_W-1:0]      m_up;
    logic [MAXL-1:0][7:0]  m_by;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            mc_q <= 1'b0;
        end else if (fire_mc) begin
            mc_q  <= 1'b1;
            m_len <= ln[0];
            m_up  <= up[0];
            m_by  <= ext[0];
        end else if (mc_ready) begin
            mc_q <= 1'b0;
        end
    end

    assign mc_valid = mc_q;
    assign mc_len   = m_len;
    assign mc_uops  = m_up;
    assign mc_bytes = m_by;

    logic [SW-1:0] uop_sum;
    always_comb begin
        uop_sum = '0;
        for (int g = 0; g < POS; g++)
            if (grp_v[g]) uop_sum = uop_sum + SW'(r_up[g]);
    end

    // R1
    flush_take_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !win_take);

    // R6
    mc_block_chk: assert property (@(posedge clk) disable iff (rst)
        mc_valid |-> !win_take);

    // R6
    mc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_valid && !mc_ready && !flush) |=> (mc_valid && $stable(mc_len) && $stable(mc_bytes)));

    // R9
    grp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((|pos_valid) && !dec_ready && !flush) |=>
            ($stable(pos_valid) && $stable(pos_len) && $stable(pos_bytes)));

    // R4
    budget_chk: assert property (@(posedge clk) disable iff (rst)
        uop_sum <= SW'(OP_BUDGET));

    // R7
    take_bound_chk: assert property (@(posedge clk) disable iff (rst)
        win_take |-> (take_len <= win_count));

    for (genvar g = 0; g + 1 < POS; g++) begin : g_order
        // R3
        order_chk: assert property (@(posedge clk) disable iff (rst)
            pos_valid[g+1] |-> pos_valid[g]);
    end

endmodule

// File: tb/steer_unit_test.sv
`timescale 1ns/1ps
module steer_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush = 1'b0;
    logic         win_valid = 1'b0;
    logic [255:0] win_bytes = '0;
    logic [159:0] win_tags = '0;
    logic [5:0]   win_count = '0;
    logic         win_take;
    logic [5:0]   take_len;
    logic         dec_ready = 1'b1;
    logic [3:0]   pos_valid;
    logic [15:0]  pos_len;
    logic [11:0]  pos_uops;
    logic [479:0] pos_bytes;
    logic         mc_valid;
    logic         mc_ready = 1'b0;
    logic [3:0]   mc_len;
    logic [2:0]   mc_uops;
    logic [119:0] mc_bytes;

    always #2 clk = ~clk;

    steer_unit uut (
        .clk(clk), .rst(rst), .flush(flush), .win_valid(win_valid),
        .win_bytes(win_bytes), .win_tags(win_tags), .win_count(win_count),
        .win_take(win_take), .take_len(take_len), .dec_ready(dec_ready),
        .pos_valid(pos_valid), .pos_len(pos_len), .pos_uops(pos_uops),
        .pos_bytes(pos_bytes), .mc_valid(mc_valid), .mc_ready(mc_ready),
        .mc_len(mc_len), .mc_uops(mc_uops), .mc_bytes(mc_bytes)
    );

    // instruction 0 sits in the rightmost element of len and up
    typedef struct packed {
        logic [5:0][3:0] len;
        logic [5:0][2:0] up;
        logic [5:0]      cnt;
        logic [2:0]      nf;
        logic            mc;
        logic [5:0]      tk;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t ROWS [NROWS] = '{
        // R3 four mixed lengths
        '{len:{4'd0,4'd0,4'd4,4'd3,4'd2,4'd1}, up:{3'd0,3'd0,3'd1,3'd1,3'd1,3'd1}, cnt:6'd32, nf:3'd4, mc:1'b0, tk:6'd10},
        // R3 position limit
        '{len:{4'd0,4'd2,4'd2,4'd2,4'd2,4'd2}, up:{3'd0,3'd1,3'd1,3'd1,3'd1,3'd1}, cnt:6'd32, nf:3'd4, mc:1'b0, tk:6'd8},
        // R4 budget 2+2 then 1 refused
        '{len:{4'd0,4'd0,4'd0,4'd3,4'd3,4'd3}, up:{3'd0,3'd0,3'd0,3'd1,3'd2,3'd2}, cnt:6'd32, nf:3'd2, mc:1'b0, tk:6'd6},
        // R4 budget 3+1 exact
        '{len:{4'd0,4'd0,4'd0,4'd2,4'd1,4'd5}, up:{3'd0,3'd0,3'd0,3'd1,3'd1,3'd3}, cnt:6'd32, nf:3'd2, mc:1'b0, tk:6'd6},
        // R5 microcode at offset 0
        '{len:{4'd0,4'd0,4'd0,4'd0,4'd0,4'd7}, up:{3'd0,3'd0,3'd0,3'd0,3'd0,3'd5}, cnt:6'd32, nf:3'd0, mc:1'b1, tk:6'd7},
        // R5 group stops before microcode instruction
        '{len:{4'd0,4'd0,4'd0,4'd4,4'd3,4'd2}, up:{3'd0,3'd0,3'd0,3'd6,3'd1,3'd1}, cnt:6'd32, nf:3'd2, mc:1'b0, tk:6'd5},
        // R7 second instruction runs past win_count
        '{len:{4'd0,4'd0,4'd0,4'd0,4'd15,4'd3}, up:{3'd0,3'd0,3'd0,3'd0,3'd1,3'd1}, cnt:6'd10, nf:3'd1, mc:1'b0, tk:6'd3},
        // R2 longest instruction, window exactly full
        '{len:{4'd0,4'd0,4'd0,4'd0,4'd0,4'd15}, up:{3'd0,3'd0,3'd0,3'd0,3'd0,3'd3}, cnt:6'd15, nf:3'd1, mc:1'b0, tk:6'd15},
        // R7 first instruction incomplete
        '{len:{4'd0,4'd0,4'd0,4'd0,4'd0,4'd6}, up:{3'd0,3'd0,3'd0,3'd0,3'd0,3'd1}, cnt:6'd4, nf:3'd0, mc:1'b0, tk:6'd0},
        // R5 count exactly four goes to microcode
        '{len:{4'd0,4'd0,4'd0,4'd0,4'd0,4'd1}, up:{3'd0,3'd0,3'd0,3'd0,3'd0,3'd4}, cnt:6'd32, nf:3'd0, mc:1'b1, tk:6'd1},
        // R4 3+3 refused
        '{len:{4'd0,4'd0,4'd0,4'd0,4'd1,4'd1}, up:{3'd0,3'd0,3'd0,3'd0,3'd3,3'd3}, cnt:6'd32, nf:3'd1, mc:1'b0, tk:6'd1},
        // R8 whole window consumed
        '{len:{4'd0,4'd0,4'd8,4'd8,4'd8,4'd8}, up:{3'd0,3'd0,3'd1,3'd1,3'd1,3'd1}, cnt:6'd32, nf:3'd4, mc:1'b0, tk:6'd32}
    };

    int compared = 0;
    int mismatched = 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int r, input int j);
        return 8'((j * 13 + r * 5 + 1) & 255);
    endfunction

    task automatic load_row(input int r);
        int off;
        off = 0;
        win_tags = '0;
        for (int j = 0; j < 32; j++) win_bytes[j*8 +: 8] = pat(r, j);
        for (int i = 0; i < 6; i++) begin
            int l;
            l = int'(ROWS[r].len[i]);
            if (l != 0 && off + l <= 32) begin
                win_tags[off*5 +: 5] = {ROWS[r].up[i], 1'b0, 1'b1};
                win_tags[(off+l-1)*5 + 1] = 1'b1;
            end
            off += l;
        end
        win_count = ROWS[r].cnt;
    endtask

    function automatic logic [119:0] exp_bytes(input int r, input int i);
        logic [119:0] b;
        int off, l;
        off = 0;
        for (int p = 0; p < i; p++) off += int'(ROWS[r].len[p]);
        l = int'(ROWS[r].len[i]);
        b = '0;
        for (int k = 0; k < 15; k++)
            if (k < l && off + k < 32) b[k*8 +: 8] = pat(r, off + k);
        return b;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(pos_valid == 4'h0, "R1 pos_valid after reset", 128'(pos_valid), 0);
        check(mc_valid == 1'b0, "R1 mc_valid after reset", 128'(mc_valid), 0);
        check(win_take == 1'b0, "R8 no take without window", 128'(win_take), 0);

        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            load_row(r);
            win_valid = 1'b1;
            dec_ready = 1'b1;
            mc_ready  = 1'b0;
            #1;
            check(win_take == (ROWS[r].tk != 0), $sformatf("R8 win_take row %0d", r), 128'(win_take), 128'(ROWS[r].tk != 0));
            check(take_len == ROWS[r].tk, $sformatf("R8 take_len row %0d", r), 128'(take_len), 128'(ROWS[r].tk));
            @(negedge clk);
            win_valid = 1'b0;
            check(pos_valid == 4'((1 << ROWS[r].nf) - 1), $sformatf("R3 pos_valid row %0d", r),
                  128'(pos_valid), 128'((1 << ROWS[r].nf) - 1));
            for (int i = 0; i < int'(ROWS[r].nf); i++) begin
                check(pos_len[i*4 +: 4] == ROWS[r].len[i], $sformatf("R2 pos_len row %0d pos %0d", r, i),
                      128'(pos_len[i*4 +: 4]), 128'(ROWS[r].len[i]));
                check(pos_bytes[i*120 +: 120] == exp_bytes(r, i), $sformatf("R10 pos_bytes row %0d pos %0d", r, i),
                      128'(pos_bytes[i*120 +: 120]), 128'(exp_bytes(r, i)));
            end
            check(mc_valid == ROWS[r].mc, $sformatf("R5 mc_valid row %0d", r), 128'(mc_valid), 128'(ROWS[r].mc));
            if (ROWS[r].mc) begin
                check(mc_len == ROWS[r].len[0], $sformatf("R5 mc_len row %0d", r), 128'(mc_len), 128'(ROWS[r].len[0]));
                check(mc_uops == ROWS[r].up[0], $sformatf("R5 mc_uops row %0d", r), 128'(mc_uops), 128'(ROWS[r].up[0]));
                check(mc_bytes == exp_bytes(r, 0), $sformatf("R10 mc_bytes row %0d", r), 128'(mc_bytes), 128'(exp_bytes(r, 0)));
            end
            mc_ready = 1'b1;
            @(negedge clk);
            mc_ready = 1'b0;
        end

        // R6 microcode stall blocks further steering
        @(negedge clk);
        load_row(4);
        win_valid = 1'b1;
        @(negedge clk);
        load_row(0);
        #1;
        check(mc_valid == 1'b1, "R6 mc_valid loaded", 128'(mc_valid), 1);
        check(win_take == 1'b0, "R6 no take while microcode pending", 128'(win_take), 0);
        repeat (3) @(negedge clk);
        check(mc_valid == 1'b1 && mc_len == 4'd7, "R6 mc held without ready", 128'({mc_valid, mc_len}), 128'({1'b1, 4'd7}));
        check(win_take == 1'b0, "R6 still no take", 128'(win_take), 0);
        mc_ready = 1'b1;
        @(negedge clk);
        mc_ready = 1'b0;
        #1;
        check(mc_valid == 1'b0, "R6 mc released", 128'(mc_valid), 0);
        check(win_take == 1'b1 && take_len == 6'd10, "R6 steering resumes", 128'({win_take, take_len}), 128'({1'b1, 6'd10}));
        @(negedge clk);
        // R9 decoder backpressure
        dec_ready = 1'b0;
        load_row(1);
        #1;
        check(win_take == 1'b0, "R9 no take while decoders stalled", 128'(win_take), 0);
        @(negedge clk);
        check(pos_valid == 4'hf && pos_len[3:0] == 4'd1, "R9 group held", 128'({pos_valid, pos_len[3:0]}), 128'({4'hf, 4'd1}));
        dec_ready = 1'b1;
        #1;
        check(win_take == 1'b1 && take_len == 6'd8, "R9 take after ready", 128'({win_take, take_len}), 128'({1'b1, 6'd8}));
        @(negedge clk);
        check(pos_len[3:0] == 4'd2, "R9 new group loaded", 128'(pos_len[3:0]), 2);

        // R1 flush clears group and microcode hand-off
        dec_ready = 1'b0;
        load_row(9);
        @(negedge clk);
        check(mc_valid == 1'b1, "R5 microcode while group pending", 128'(mc_valid), 1);
        flush = 1'b1;
        load_row(0);
        #1;
        check(win_take == 1'b0, "R1 no take during flush", 128'(win_take), 0);
        @(negedge clk);
        flush = 1'b0;
        win_valid = 1'b0;
        check(pos_valid == 4'h0, "R1 pos_valid after flush", 128'(pos_valid), 0);
        check(mc_valid == 1'b0, "R1 mc_valid after flush", 128'(mc_valid), 0);
        dec_ready = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule